// File: doc/BRIEF.md
# Reset-Time Boot Address Selector

This block keeps two non-volatile configuration bytes, a boot-mode byte and a boot page byte, and decides where execution begins when reset is released. On the first clock edge after the active-high reset drops, it looks at the boot-mode byte and at five strap inputs. It then loads a 16-bit start address and raises a valid strobe for exactly one clock. If the boot-mode byte is zero and the straps do not request the loader, execution begins at 0x0000. Otherwise it begins at the boot page byte followed by a zero low byte. The start address holds its value until the next reset release.

A host changes the bytes through a single-cycle command port. A program command can only clear bits, as flash does. An erase command sets both bytes to 0xFF together, so the boot page must be programmed again afterwards. At power-on the bytes hold the factory setting: boot-mode 0xFF and boot page 0xFC, which gives a start address of 0xFC00, the base of a 1 kB boot ROM.

A separate combinational decoder, which needs no clock, maps any 16-bit program address to a flash block index and flags addresses that fall in the boot ROM window.

Top module: `boot_start_sel`

## Requirements
- R1: When the boot-mode byte is 0x00 and the strap combination is not present at reset release, start_addr becomes 0x0000.
- R2: When the boot-mode byte is non-zero at reset release, start_addr becomes {boot page byte, 8'h00}.
- R3: When strap_fetch_n=0, strap_sel_a=1, strap_sel_b=1, strap_ext=1 and strap_latch=1 all hold at reset release, start_addr becomes {boot page byte, 8'h00} even if the boot-mode byte is zero. Any other strap combination does not force this.
- R4: start_valid is high for exactly one clock, in the cycle after the first rising edge at which rst is low following a rst-high edge. start_addr changes only in that cycle and holds at all other times.
- R5: cmd_op=2'b11 (erase) sets both the boot-mode byte and the boot page byte to 0xFF. An erased part therefore starts at 0xFF00.
- R6: cmd_op=2'b01 programs the boot-mode byte and cmd_op=2'b10 programs the boot page byte. Each stores the bitwise AND of cmd_data with the old value. cmd_op=2'b00 does nothing.
- R7: Commands presented while rst is high have no effect.
- R8: At power-on the boot-mode byte is 0xFF and the boot page byte is 0xFC, so the first reset release gives start_addr 0xFC00.
- R9: dec_block is 0 for 0x0000-0x1FFF, 1 for 0x2000-0x3FFF, 2 for 0x4000-0x7FFF, 3 for 0x8000-0xBFFF and 4 for 0xC000-0xFFFF.
- R10: dec_boot_rom is 1 exactly for addresses 0xFC00-0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset; its release triggers start-address selection |
| strap_fetch_n | input | 1 | Strap sampled at release; must be low to force the loader |
| strap_sel_a | input | 1 | Strap sampled at release; must be high to force the loader |
| strap_sel_b | input | 1 | Strap sampled at release; must be high to force the loader |
| strap_ext | input | 1 | Strap sampled at release; must be high to force the loader |
| strap_latch | input | 1 | Strap sampled at release; must be high to force the loader |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_op | input | 2 | 00 none, 01 program boot-mode, 10 program boot page, 11 erase both |
| cmd_data | input | 8 | Data for program commands |
| start_addr | output | 16 | Selected start address |
| start_valid | output | 1 | One-clock pulse after selection |
| dec_addr | input | 16 | Address to decode |
| dec_block | output | 3 | Flash block index 0-4 |
| dec_boot_rom | output | 1 | Address lies in the boot ROM window |

## Verification
The embedded assertions check several properties on every cycle. The valid strobe lasts one clock and follows a reset release. The start address changes only alongside that strobe and always has a zero low byte. An erase leaves both bytes at 0xFF, and programming never sets a bit. A boot ROM hit always decodes as block 4. Other behaviour can only be shown by the bench's directed scenarios. These cover the actual address chosen for each combination of stored bytes and straps, the factory power-on address, the exact AND results of programming, commands that are dropped during reset, and the block boundaries.

// File: rtl/boot_start_sel.sv
module boot_start_sel #(
  parameter logic [7:0] INIT_MODE = 8'hFF,
  parameter logic [7:0] INIT_PAGE = 8'hFC,
  parameter logic [7:0] ERASED    = 8'hFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        strap_fetch_n,
  input  logic        strap_sel_a,
  input  logic        strap_sel_b,
  input  logic        strap_ext,
  input  logic        strap_latch,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [7:0]  cmd_data,
  output logic [15:0] start_addr,
  output logic        start_valid,
  input  logic [15:0] dec_addr,
  output logic [2:0]  dec_block,
  output logic        dec_boot_rom
);

  localparam logic [1:0] OP_MODE  = 2'b01;
  localparam logic [1:0] OP_PAGE  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  logic [7:0]  mode_q = INIT_MODE;
  logic [7:0]  page_q = INIT_PAGE;
  logic        rst_q  = 1'b0;
  logic [15:0] addr_q = 16'h0000;
  logic        vld_q;

  wire release_now = rst_q && !rst;
  wire strap_force = !strap_fetch_n && strap_sel_a && strap_sel_b && strap_ext && strap_latch;
  wire use_page    = (mode_q != 8'h00) || strap_force;
  wire cmd_live    = cmd_valid && !rst;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (cmd_live) begin
      case (cmd_op)
        OP_MODE:  mode_q <= mode_q & cmd_data;
        OP_PAGE:  page_q <= page_q & cmd_data;
        OP_ERASE: begin
          mode_q <= ERASED;
          page_q <= ERASED;
        end
        default: ;
      endcase
    end
    if (release_now) addr_q <= use_page ? {page_q, 8'h00} : 16'h0000;
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= release_now;
  end

  assign start_addr  = addr_q;
  assign start_valid = vld_q;

  always_comb begin
    if (dec_addr[15:14] == 2'b11) dec_block = 3'd4;
    else if (dec_addr[15])        dec_block = 3'd3;
    else if (dec_addr[14])        dec_block = 3'd2;
    else if (dec_addr[13])        dec_block = 3'd1;
    else                          dec_block = 3'd0;
  end

  assign dec_boot_rom = (dec_addr[15:10] == 6'b111111);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    start_valid |=> !start_valid);

  a_r4_after_release: assert property (@(posedge clk) disable iff (rst)
    start_valid |-> $past(rst, 2));

  a_r4_addr_holds: assert property (@(posedge clk) disable iff (rst)
    !start_valid |-> $stable(start_addr));

  a_r2_low_byte_zero: assert property (@(posedge clk) disable iff (rst)
    start_valid |-> (start_addr[7:0] == 8'h00));

  a_r5_erase_both: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_live && cmd_op == OP_ERASE) |-> (mode_q == ERASED && page_q == ERASED));

  a_r6_clear_only: assert property (@(posedge clk) disable iff (rst)
    $past(!(cmd_live && cmd_op == OP_ERASE)) |->
      ((mode_q & ~$past(mode_q)) == 8'h00 && (page_q & ~$past(page_q)) == 8'h00));

  a_r7_reset_blocks: assert property (@(posedge clk)
    $past(rst) |-> ($stable(mode_q) && $stable(page_q)));

  always_comb begin
    a_r10_rom_in_top_block: assert (!dec_boot_rom || dec_block == 3'd4);
  end

endmodule

// File: tb/test_boot_start_sel.sv
module test_boot_start_sel;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_fetch_n = 1'b1, strap_sel_a = 1'b0, strap_sel_b = 1'b0;
  logic strap_ext = 1'b0, strap_latch = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_data = 8'h00;
  logic [15:0] start_addr, dec_addr = 16'h0000;
  logic start_valid, dec_boot_rom;
  logic [2:0] dec_block;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  boot_start_sel i_boot_start_sel (
    .clk(clk), .rst(rst),
    .strap_fetch_n(strap_fetch_n), .strap_sel_a(strap_sel_a), .strap_sel_b(strap_sel_b),
    .strap_ext(strap_ext), .strap_latch(strap_latch),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .start_addr(start_addr), .start_valid(start_valid),
    .dec_addr(dec_addr), .dec_block(dec_block), .dec_boot_rom(dec_boot_rom)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00; cmd_data = 8'h00;
  endtask

  task automatic set_straps(input logic f_n, input logic a, input logic b, input logic e, input logic l);
    strap_fetch_n = f_n; strap_sel_a = a; strap_sel_b = b; strap_ext = e; strap_latch = l;
  endtask

  task automatic boot(input logic [15:0] exp, input string tag);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check(start_valid == 1'b1, {tag, " valid pulse"}, start_valid, 1);
    check(start_addr == exp, tag, start_addr, exp);
    @(posedge clk); #1;
    check(start_valid == 1'b0, "R4 pulse width", start_valid, 0);
  endtask

  task automatic t_power_on;
    #1;
    check(start_valid == 1'b0, "R4 reset state", start_valid, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check(start_valid == 1'b1, "R4 first pulse", start_valid, 1);
    check(start_addr == 16'hFC00, "R8 factory address", start_addr, 16'hFC00);
    @(posedge clk); #1;
    check(start_valid == 1'b0, "R4 pulse width", start_valid, 0);
  endtask

  task automatic t_user_boot;
    send(2'b01, 8'h00);
    send(2'b00, 8'h00);
    boot(16'h0000, "R1 zero mode");
    repeat (5) @(posedge clk);
    #1;
    check(start_addr == 16'h0000 && !start_valid, "R4 address holds", start_addr, 0);
  endtask

  task automatic t_straps;
    set_straps(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    boot(16'hFC00, "R3 strap force");
    set_straps(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    boot(16'h0000, "R3 partial straps");
    set_straps(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    boot(16'h0000, "R3 fetch strap high");
    set_straps(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_cmd_in_reset;
    @(negedge clk); rst = 1'b1;
    cmd_valid = 1'b1; cmd_op = 2'b11;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    boot(16'h0000, "R7 erase during reset");
  endtask

  task automatic t_erase;
    send(2'b11, 8'h00);
    boot(16'hFF00, "R5 erased boot");
  endtask

  task automatic t_program;
    send(2'b10, 8'h3C);
    boot(16'h3C00, "R6 program page");
    send(2'b10, 8'hF0);
    boot(16'h3000, "R6 page AND");
    send(2'b01, 8'h0F);
    boot(16'h3000, "R6 mode still nonzero R2");
    send(2'b01, 8'hF0);
    boot(16'h0000, "R6 mode AND to zero");
  endtask

  task automatic dchk(input logic [15:0] a, input logic [2:0] blk, input logic rom);
    dec_addr = a; #1;
    check(dec_block == blk, "R9 block", dec_block, blk);
    check(dec_boot_rom == rom, "R10 boot rom", dec_boot_rom, rom);
  endtask

  task automatic t_decode;
    dchk(16'h0000, 3'd0, 1'b0); dchk(16'h1FFF, 3'd0, 1'b0);
    dchk(16'h2000, 3'd1, 1'b0); dchk(16'h3FFF, 3'd1, 1'b0);
    dchk(16'h4000, 3'd2, 1'b0); dchk(16'h7FFF, 3'd2, 1'b0);
    dchk(16'h8000, 3'd3, 1'b0); dchk(16'hBFFF, 3'd3, 1'b0);
    dchk(16'hC000, 3'd4, 1'b0); dchk(16'hFBFF, 3'd4, 1'b0);
    dchk(16'hFC00, 3'd4, 1'b1); dchk(16'hFFFF, 3'd4, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_power_on;
    t_user_boot;
    t_straps;
    t_cmd_in_reset;
    t_erase;
    t_program;
    t_decode;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule